// File: doc/BRIEF.md
# Processor Startup IPI Sequencer

This block wakes a sleeping processor by issuing the three-message wake-up protocol: one INIT message, then two identical start-up messages. It contains a model of a two-word interrupt command register. For each message the block first writes the high word, which carries the destination, and then the low word, which carries the message type and vector. Writing the low word launches the message and raises a delivery-status bit. The block then waits, for as many cycles as it takes, until the target acknowledges on the `accept` input. That input clears the status bit. Between messages the block inserts timed gaps, counted in clock cycles as `CYCLES_PER_US` times a number of microseconds.

A request arrives on a valid/ready interface. It carries an 8-bit destination ID, a start-up address and a flag that broadcasts the sequence to every processor except the sender. `req_ready` is high only while the block is idle. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. The fields must stay stable until that edge, and a requester that sees `req_ready` low holds its request. The start-up vector is the address divided by 4096. An address that is not page aligned, or that lies at or above 1 MB, is refused: the block flags an error and sends nothing.

Top module: `startup_ipi_seq`

## Requirements
- R1: For every message the high command word is written before the low word. The high word holds the destination ID in bits 31:24 and zeros in bits 23:0.
- R2: A low-word write launches a message and sets the status bit (low word bit 12) to 1. The bit stays 1 until `accept` is high in a cycle. No further message is launched while it is 1, however long `accept` stays low.
- R3: The messages go out in the order INIT, start-up, start-up. The mode field in low bits 10:8 is 101 for INIT and 110 for start-up. INIT carries vector 0. The two start-up words are identical.
- R4: At least `CYCLES_PER_US`*10 cycles pass from the acceptance of INIT to the launch of the first start-up. At least `CYCLES_PER_US`*200 cycles pass from the acceptance of the first start-up to the launch of the second. Each gap is at most 4 cycles longer than its minimum.
- R5: The start-up vector in low bits 7:0 equals the request address shifted right by 12.
- R6: Every launched low word has the level bit (bit 14) at 1 and the trigger bit (bit 15) at 0.
- R7: With broadcast set, low bits 19:18 are 11 and the high word is all zeros. Without broadcast, bits 19:18 are 00.
- R8: A request whose address is at or above 0x100000, or has nonzero bits 11:0, raises `err` for exactly one cycle. No message is launched, `done` and `busy` stay low, and the block is ready again in the next cycle.
- R9: `req_ready` is high only while `busy` is low. `busy` is high from the cycle after an accepted request until the final acceptance is seen. `done` pulses for one cycle as `busy` falls.
- R10: After reset, `busy`, `done` and `err` are low, `req_ready` is high and both command words are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_dest | input | 8 | Destination processor ID |
| req_addr | input | ADDR_W | Start-up routine address |
| req_bcast | input | 1 | Send to all processors except self |
| accept | input | 1 | Target acknowledges the pending message |
| icr_hi | output | 32 | High command word as written |
| icr_lo | output | 32 | Low command word, bit 12 is delivery status |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse when the sequence completes |
| err | output | 1 | One-cycle pulse when a request is refused |

## Verification
The sequence is run with a unicast destination and no acknowledge stall, with a broadcast request that stalls the acknowledge by a different amount for each message, and with a long stall on INIT. Together these separate the field encoding per mode from the handshake and gap timing. The boundary addresses 0x00000 and 0xFF000 and destination 0xFF show whether the vector and ID fields are sliced correctly. A misaligned address and an address at 1 MB, each followed by a good request, show that a refusal sends nothing and leaves the block usable.

// File: rtl/ipi_seq_pkg.sv
package ipi_seq_pkg;

  localparam int WORD_W = 32;
  localparam int VEC_W  = 8;
  localparam int ID_W   = 8;

  typedef enum logic [2:0] {
    MODE_FIXED   = 3'b000,
    MODE_INIT    = 3'b101,
    MODE_STARTUP = 3'b110
  } msg_mode_e;

  typedef enum logic [1:0] {
    DST_EXPLICIT     = 2'b00,
    DST_ALL_BUT_SELF = 2'b11
  } dst_sel_e;

  typedef enum logic [1:0] {
    STEP_INIT   = 2'd0,
    STEP_WAKE_A = 2'd1,
    STEP_WAKE_B = 2'd2
  } step_e;

  typedef struct packed {
    logic [11:0] rsvd_top;
    dst_sel_e    dst_sel;
    logic [1:0]  rsvd_mid;
    logic        trigger;
    logic        level;
    logic        rsvd_b13;
    logic        pending;
    logic        logical;
    msg_mode_e   mode;
    logic [VEC_W-1:0] vector;
  } cmd_low_t;

  function automatic logic [WORD_W-1:0] make_low(input step_e step,
                                                 input logic [VEC_W-1:0] vec,
                                                 input logic bcast);
    cmd_low_t w;
    w          = '0;
    w.level    = 1'b1;
    w.trigger  = 1'b0;
    w.dst_sel  = bcast ? DST_ALL_BUT_SELF : DST_EXPLICIT;
    if (step == STEP_INIT) begin
      w.mode   = MODE_INIT;
      w.vector = '0;
    end else begin
      w.mode   = MODE_STARTUP;
      w.vector = vec;
    end
    return w;
  endfunction

endpackage

// File: rtl/ipi_addr_check.sv
module ipi_addr_check #(
  parameter int ADDR_W     = 32,
  parameter int PAGE_BITS  = 12,
  parameter int LIMIT_BITS = 20
) (
  input  logic [ADDR_W-1:0]              addr,
  output logic                           addr_ok,
  output logic [ipi_seq_pkg::VEC_W-1:0]  vector
);
  localparam int VEC_W = ipi_seq_pkg::VEC_W;

  logic below_limit;
  logic aligned;

  generate
    if (ADDR_W > LIMIT_BITS) begin : g_limit
      assign below_limit = (addr[ADDR_W-1:LIMIT_BITS] == '0);
    end else begin : g_nolimit
      assign below_limit = 1'b1;
    end
  endgenerate

  assign aligned = (addr[PAGE_BITS-1:0] == '0);
  assign addr_ok = below_limit && aligned;
  assign vector  = addr[PAGE_BITS +: VEC_W];

endmodule

// File: rtl/ipi_cmd_reg.sv
module ipi_cmd_reg #(
  parameter int WORD_W     = 32,
  parameter int STATUS_BIT = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hi_wr,
  input  logic              lo_wr,
  input  logic [WORD_W-1:0] wdata,
  input  logic              accept,
  output logic [WORD_W-1:0] hi_q,
  output logic [WORD_W-1:0] lo_q,
  output logic              pending
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_q <= '0;
      lo_q <= '0;
    end else begin
      if (hi_wr) hi_q <= wdata;
      if (lo_wr) begin
        lo_q             <= wdata;
        lo_q[STATUS_BIT] <= 1'b1;
      end else if (accept && lo_q[STATUS_BIT]) begin
        lo_q[STATUS_BIT] <= 1'b0;
      end
    end
  end

  assign pending = lo_q[STATUS_BIT];

  assert_status_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !accept) |=> pending);

  assert_status_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && accept && !lo_wr) |=> !pending);

  assert_launch_sets_status_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lo_wr |=> pending);

endmodule

// File: rtl/ipi_gap_timer.sv
module ipi_gap_timer #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] count;

  always_ff @(posedge clk) begin
    if (!rst_n)              count <= '0;
    else if (load)           count <= load_val;
    else if (count != '0)    count <= count - 1'b1;
  end

  assign expired = (count == '0);

  assert_timer_descends_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && count != '0) |=> (count == $past(count) - 1'b1));

endmodule

// File: rtl/ipi_seq_ctrl.sv
module ipi_seq_ctrl #(
  parameter int CYCLES_PER_US = 4,
  parameter int INIT_GAP_US   = 10,
  parameter int WAKE_GAP_US   = 200,
  parameter int CNT_W         = 10
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          req_valid,
  output logic                          req_ready,
  input  logic [ipi_seq_pkg::ID_W-1:0]  req_dest,
  input  logic                          req_bcast,
  input  logic                          addr_ok,
  input  logic [ipi_seq_pkg::VEC_W-1:0] req_vec,
  input  logic                          pending,
  input  logic                          gap_done,
  output logic                          hi_wr,
  output logic                          lo_wr,
  output logic [ipi_seq_pkg::WORD_W-1:0] wdata,
  output logic                          gap_load,
  output logic [CNT_W-1:0]              gap_val,
  output logic                          busy,
  output logic                          done,
  output logic                          err
);
  import ipi_seq_pkg::*;

  localparam int INIT_GAP_CYC = CYCLES_PER_US * INIT_GAP_US;
  localparam int WAKE_GAP_CYC = CYCLES_PER_US * WAKE_GAP_US;
  localparam logic [CNT_W-1:0] INIT_LOAD = CNT_W'(INIT_GAP_CYC - 1);
  localparam logic [CNT_W-1:0] WAKE_LOAD = CNT_W'(WAKE_GAP_CYC - 1);

  typedef enum logic [2:0] {
    S_IDLE, S_WR_HI, S_WR_LO, S_WAIT_ACK, S_GAP
  } state_e;

  state_e             state;
  step_e              step;
  logic [ID_W-1:0]    dest_q;
  logic [VEC_W-1:0]   vec_q;
  logic               bcast_q;
  logic               take;
  logic               acked;

  assign req_ready = (state == S_IDLE);
  assign busy      = (state != S_IDLE);
  assign take      = req_valid && req_ready;
  assign acked     = (state == S_WAIT_ACK) && !pending;

  assign hi_wr     = (state == S_WR_HI);
  assign lo_wr     = (state == S_WR_LO);
  assign gap_load  = acked && (step != STEP_WAKE_B);
  assign gap_val   = (step == STEP_INIT) ? INIT_LOAD : WAKE_LOAD;

  always_comb begin
    if (state == S_WR_HI)
      wdata = {(bcast_q ? {ID_W{1'b0}} : dest_q), {(WORD_W-ID_W){1'b0}}};
    else
      wdata = make_low(step, vec_q, bcast_q);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      step    <= STEP_INIT;
      dest_q  <= '0;
      vec_q   <= '0;
      bcast_q <= 1'b0;
      done    <= 1'b0;
      err     <= 1'b0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      case (state)
        S_IDLE: begin
          if (take) begin
            if (addr_ok) begin
              dest_q  <= req_dest;
              vec_q   <= req_vec;
              bcast_q <= req_bcast;
              step    <= STEP_INIT;
              state   <= S_WR_HI;
            end else begin
              err <= 1'b1;
            end
          end
        end
        S_WR_HI:    state <= S_WR_LO;
        S_WR_LO:    state <= S_WAIT_ACK;
        S_WAIT_ACK: begin
          if (!pending) begin
            if (step == STEP_WAKE_B) begin
              state <= S_IDLE;
              done  <= 1'b1;
            end else begin
              step  <= (step == STEP_INIT) ? STEP_WAKE_A : STEP_WAKE_B;
              state <= S_GAP;
            end
          end
        end
        S_GAP: begin
          if (gap_done) state <= S_WR_HI;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assert_low_follows_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
    lo_wr |-> $past(hi_wr));

  assert_no_launch_while_pending_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lo_wr |-> !pending);

  assert_level_bit_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    lo_wr |-> (wdata[14] && !wdata[15]));

  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_after_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(busy) && !busy));

  assert_refusal_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!busy && !done));

endmodule

// File: rtl/startup_ipi_seq.sv
module startup_ipi_seq #(
  parameter int ADDR_W        = 32,
  parameter int CYCLES_PER_US = 4,
  parameter int INIT_GAP_US   = 10,
  parameter int WAKE_GAP_US   = 200,
  parameter int PAGE_BITS     = 12,
  parameter int LIMIT_BITS    = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [7:0]        req_dest,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_bcast,
  input  logic              accept,
  output logic [31:0]       icr_hi,
  output logic [31:0]       icr_lo,
  output logic              busy,
  output logic              done,
  output logic              err
);
  import ipi_seq_pkg::*;

  localparam int MAX_GAP = CYCLES_PER_US *
                           ((WAKE_GAP_US > INIT_GAP_US) ? WAKE_GAP_US : INIT_GAP_US);
  localparam int CNT_W   = $clog2(MAX_GAP + 1);

  logic              addr_ok;
  logic [VEC_W-1:0]  req_vec;
  logic              pending;
  logic              gap_done;
  logic              hi_wr;
  logic              lo_wr;
  logic [WORD_W-1:0] wdata;
  logic              gap_load;
  logic [CNT_W-1:0]  gap_val;

  ipi_addr_check #(
    .ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS), .LIMIT_BITS(LIMIT_BITS)
  ) u_addr (
    .addr(req_addr), .addr_ok(addr_ok), .vector(req_vec)
  );

  ipi_seq_ctrl #(
    .CYCLES_PER_US(CYCLES_PER_US), .INIT_GAP_US(INIT_GAP_US),
    .WAKE_GAP_US(WAKE_GAP_US), .CNT_W(CNT_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_dest(req_dest), .req_bcast(req_bcast),
    .addr_ok(addr_ok), .req_vec(req_vec),
    .pending(pending), .gap_done(gap_done),
    .hi_wr(hi_wr), .lo_wr(lo_wr), .wdata(wdata),
    .gap_load(gap_load), .gap_val(gap_val),
    .busy(busy), .done(done), .err(err)
  );

  ipi_cmd_reg #(.WORD_W(WORD_W), .STATUS_BIT(12)) u_cmd (
    .clk(clk), .rst_n(rst_n),
    .hi_wr(hi_wr), .lo_wr(lo_wr), .wdata(wdata), .accept(accept),
    .hi_q(icr_hi), .lo_q(icr_lo), .pending(pending)
  );

  ipi_gap_timer #(.CNT_W(CNT_W)) u_gap (
    .clk(clk), .rst_n(rst_n),
    .load(gap_load), .load_val(gap_val), .expired(gap_done)
  );

  assert_ready_only_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !busy);

endmodule

// File: tb/startup_ipi_seq_test.sv
module startup_ipi_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int CPU        = 4;
  localparam int GAP_INIT   = CPU * 10;
  localparam int GAP_WAKE   = CPU * 200;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [7:0]  req_dest = '0;
  logic [31:0] req_addr = '0;
  logic        req_bcast = 1'b0;
  logic        accept = 1'b0;
  logic [31:0] icr_hi, icr_lo;
  logic        busy, done, err;

  int tests = 0;
  int fails = 0;
  int cyc   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  startup_ipi_seq #(.CYCLES_PER_US(CPU)) uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_dest(req_dest), .req_addr(req_addr), .req_bcast(req_bcast),
    .accept(accept), .icr_hi(icr_hi), .icr_lo(icr_lo),
    .busy(busy), .done(done), .err(err)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic send_req(input logic [7:0] d, input logic [31:0] a, input logic b);
    @(negedge clk);
    req_valid = 1'b1; req_dest = d; req_addr = a; req_bcast = b;
    @(negedge clk);
    req_valid = 1'b0; req_dest = 8'h00; req_addr = '0; req_bcast = 1'b0;
  endtask

  function automatic logic [31:0] exp_low(input int m, input logic [31:0] a, input logic b);
    logic [31:0] w;
    w = 32'h0000_5000;
    if (b) w |= 32'h000C_0000;
    if (m == 0) w |= 32'h0000_0500;
    else        w |= 32'h0000_0600 | {24'h0, a[19:12]};
    return w;
  endfunction

  task automatic run_seq(input logic [7:0] d, input logic [31:0] a, input logic b,
                         input int st0, input int st1, input int st2);
    int stall[3];
    int t_acc;
    int gap;
    logic [31:0] first_wake;
    bit seen;
    stall[0] = st0; stall[1] = st1; stall[2] = st2;
    t_acc = 0;
    first_wake = '0;
    send_req(d, a, b);
    check(busy && !req_ready, "R9", "busy/ready after request", {30'h0, busy, req_ready}, 32'h2);
    for (int m = 0; m < 3; m++) begin
      seen = 0;
      for (int k = 0; k < 2000 && !seen; k++) begin
        if (icr_lo[12]) seen = 1;
        else @(negedge clk);
      end
      check(seen, "R2", "launch seen", {31'h0, seen}, 32'h1);
      if (m > 0) begin
        gap = cyc - t_acc;
        if (m == 1)
          check(gap >= GAP_INIT && gap <= GAP_INIT + 4, "R4", "INIT to wake gap",
                gap, GAP_INIT);
        else
          check(gap >= GAP_WAKE && gap <= GAP_WAKE + 4, "R4", "wake to wake gap",
                gap, GAP_WAKE);
      end
      check(icr_hi === (b ? 32'h0 : {d, 24'h0}), b ? "R7" : "R1", "high word",
            icr_hi, b ? 32'h0 : {d, 24'h0});
      check(icr_lo === exp_low(m, a, b), m == 0 ? "R3" : "R5", "low word",
            icr_lo, exp_low(m, a, b));
      check(icr_lo[14] && !icr_lo[15], "R6", "level/trigger", icr_lo, 32'h4000);
      if (m == 1) first_wake = icr_lo;
      if (m == 2) check(icr_lo === first_wake, "R3", "second wake identical", icr_lo, first_wake);
      for (int s = 0; s < stall[m]; s++) @(negedge clk);
      check(icr_lo[12] && busy, "R2", "status held while stalled", icr_lo, 32'h1000);
      accept = 1'b1;
      @(negedge clk);
      accept = 1'b0;
      t_acc = cyc;
      check(!icr_lo[12], "R2", "status cleared by accept", {31'h0, icr_lo[12]}, 32'h0);
    end
    seen = 0;
    for (int k = 0; k < 6 && !seen; k++) begin
      @(negedge clk);
      if (done) seen = 1;
    end
    check(seen && !busy && req_ready, "R9", "done with busy low",
          {29'h0, seen, busy, req_ready}, 32'h5);
    @(negedge clk);
    check(!done, "R9", "done one cycle", {31'h0, done}, 32'h0);
  endtask

  task automatic bad_req(input logic [31:0] a);
    logic [31:0] lo_before;
    bit launched;
    lo_before = icr_lo;
    launched = 0;
    send_req(8'h12, a, 1'b0);
    check(err && !busy && req_ready, "R8", "refusal flags",
          {29'h0, err, busy, req_ready}, 32'h5);
    @(negedge clk);
    check(!err, "R8", "err one cycle", {31'h0, err}, 32'h0);
    for (int k = 0; k < 20; k++) begin
      if (icr_lo[12] || busy || done || icr_lo !== lo_before) launched = 1;
      @(negedge clk);
    end
    check(!launched, "R8", "nothing sent", icr_lo, lo_before);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !done && !err && req_ready, "R10", "reset flags",
          {28'h0, busy, done, err, req_ready}, 32'h1);
    check(icr_hi === 32'h0 && icr_lo === 32'h0, "R10", "reset words", icr_lo, 32'h0);

    run_seq(8'h3A, 32'h0009_F000, 1'b0, 0, 0, 0);
    run_seq(8'h55, 32'h0000_8000, 1'b1, 3, 17, 1);
    run_seq(8'hFF, 32'h000F_F000, 1'b0, 40, 2, 9);
    run_seq(8'h01, 32'h0000_0000, 1'b0, 1, 1, 1);
    bad_req(32'h0009_F800);
    bad_req(32'h0010_0000);
    run_seq(8'h07, 32'h0000_1000, 1'b1, 0, 5, 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule